// File: doc/BRIEF.md
# Serial Disc Read Channel with Odd-Parity Check

This block turns the serial read stream of a disc into 16-bit words for a DMA engine. A frame is 17 bits long: 16 data bits with the least significant bit first, then one parity bit. The frame is good when it holds an odd number of ones. When the seventeenth bit arrives, the assembled word is copied into a holding register and a service flag is raised so the DMA collects it. The DMA lowers the flag with a clear strobe.

Software starts a read with a set-control strobe. This sets the control bit, arms the channel, resets the parity tracker and clears the error and overrun indications. The parity tracker is one flip-flop that flips on every zero received, including the parity bit. If it is high when a frame ends, a parity error is latched. The error stays latched until the next read start, so only the first error of an operation is recorded. Dropping the control bit does not stop reading at once. The channel finishes the current sector and goes idle at the next end-of-sector pulse.

Top module: `disc_rd_channel`

## Requirements
- R1: Data bits are assembled least significant bit first, so the first bit of a frame appears at bit 0 of `rd_word`.
- R2: `rd_word` changes only in the cycle after the seventeenth bit of a frame is accepted, and it holds its value between frames.
- R3: `svc_flag` rises in the cycle after a frame completes. A `flag_clr` pulse lowers it. If a frame completes in the same cycle as `flag_clr`, the flag stays high.
- R4: `par_err` rises after a frame whose 17 bits contain an even number of ones. This is tracked by a flip-flop that `ctl_set` resets to 0 and that every accepted zero bit toggles.
- R5: Once `par_err` is set, it stays set through later frames until the next `ctl_set` or power-on clear.
- R6: The parity bit is never stored in `rd_word`. The word holds only the 16 data bits.
- R7: `ser_vld` strobes have no effect while the channel is idle: nothing is assembled, and neither the flag nor the word changes.
- R8: While the control bit is set, an `sector_end` pulse keeps the channel active. After `ctl_clr`, the channel goes idle (`rd_active` = 0) at the next `sector_end`.
- R9: If a frame completes while `svc_flag` is still high and `flag_clr` is not asserted, `overrun` is set and `rd_word` still takes the new word. `ctl_set` clears `overrun`.
- R10: While `por_n` is low, `rd_word`, `svc_flag`, `par_err`, `overrun` and `rd_active` are all 0.
- R11: A `sector_end` pulse discards a partly received frame, so the next accepted bit is bit 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| ser_bit | input | 1 | Serial read data |
| ser_vld | input | 1 | One-cycle strobe that qualifies `ser_bit` |
| ctl_set | input | 1 | Starts a read: sets the control bit and arms the channel |
| ctl_clr | input | 1 | Clears the control bit |
| flag_clr | input | 1 | Lowers the service flag |
| sector_end | input | 1 | End-of-sector pulse |
| rd_word | output | 16 | Last completed data word |
| svc_flag | output | 1 | A new word is waiting for DMA pickup |
| par_err | output | 1 | Sticky parity error |
| overrun | output | 1 | A word was replaced before it was collected |
| rd_active | output | 1 | Channel is accepting bits |

## Verification
Frames are tried in several patterns:
- All zeros and all ones, which separate shift direction from parity-count mistakes.
- Single set bits at either end of the word, which expose bit-order reversal and parity bits leaking into the word.
- Mixed patterns, half of them with a wrong parity bit, which separate the zero-toggle odd check from an even check or a one-toggle check.

Follow-on tests combine good and bad frames in one operation to show that the error is sticky. They also hold `flag_clr` during a frame's last bit, leave the flag high across two frames to force an overrun, and cut a frame short with `sector_end`.

// File: rtl/disc_rd_pkg.sv
package disc_rd_pkg;
  localparam int unsigned WORD_W = 16;

  // Next state of the read-parity tracker: flips on every zero bit
  function automatic logic par_step(input logic par_q, input logic bit_in);
    return par_q ^ ~bit_in;
  endfunction

  // Frame is bad when the tracker ends high after the last bit
  function automatic logic frame_bad(input logic par_q, input logic last_bit);
    return par_step(par_q, last_bit);
  endfunction
endpackage

// File: rtl/rd_deser.sv
module rd_deser #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          en,
  input  logic          restart,
  input  logic          bit_in,
  output logic [DW-1:0] word_q,
  output logic          word_done
);
  localparam int unsigned FW = DW + 1;
  localparam int unsigned CW = $clog2(FW);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sr_q;
  logic          last_bit;
  logic          data_bit;

  assign last_bit  = (cnt_q == CW'(FW - 1));
  assign data_bit  = (cnt_q < CW'(DW));
  assign word_done = en && last_bit;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      sr_q   <= '0;
      word_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (en) begin
      if (last_bit) begin
        cnt_q  <= '0;
        word_q <= sr_q;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (data_bit) sr_q <= {bit_in, sr_q[DW-1:1]};
    end
  end

  a_r2_word_hold: assert property (@(posedge clk) disable iff (!por_n)
    !word_done |=> $stable(word_q));
  a_r11_restart_count: assert property (@(posedge clk) disable iff (!por_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/rd_parity.sv
module rd_parity
  import disc_rd_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic start,
  input  logic en,
  input  logic bit_in,
  input  logic word_done,
  output logic par_err
);
  logic par_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      par_q   <= 1'b0;
      par_err <= 1'b0;
    end else if (start) begin
      par_q   <= 1'b0;
      par_err <= 1'b0;
    end else if (en) begin
      par_q <= par_step(par_q, bit_in);
      if (word_done && frame_bad(par_q, bit_in)) par_err <= 1'b1;
    end
  end

  a_r4_start_clears: assert property (@(posedge clk) disable iff (!por_n)
    start |=> (!par_q && !par_err));
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (par_err && !start) |=> par_err);
endmodule

// File: rtl/rd_ctrl.sv
module rd_ctrl (
  input  logic clk,
  input  logic por_n,
  input  logic ctl_set,
  input  logic ctl_clr,
  input  logic sector_end,
  input  logic flag_clr,
  input  logic word_done,
  output logic active,
  output logic svc_flag,
  output logic overrun
);
  logic ctl_q;
  logic overrun_evt;

  assign overrun_evt = word_done && svc_flag && !flag_clr;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl_q    <= 1'b0;
      active   <= 1'b0;
      svc_flag <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (ctl_set)      ctl_q <= 1'b1;
      else if (ctl_clr) ctl_q <= 1'b0;

      if (ctl_set)                   active <= 1'b1;
      else if (sector_end && !ctl_q) active <= 1'b0;

      if (word_done)     svc_flag <= 1'b1;
      else if (flag_clr) svc_flag <= 1'b0;

      if (ctl_set)          overrun <= 1'b0;
      else if (overrun_evt) overrun <= 1'b1;
    end
  end

  a_r3_flag_rises: assert property (@(posedge clk) disable iff (!por_n)
    word_done |=> svc_flag);
  a_r9_overrun: assert property (@(posedge clk) disable iff (!por_n)
    overrun_evt |=> overrun);
  a_r8_stop_at_sector: assert property (@(posedge clk) disable iff (!por_n)
    (sector_end && !ctl_q && !ctl_set) |=> !active);
endmodule

// File: rtl/disc_rd_channel.sv
module disc_rd_channel
  import disc_rd_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          ser_bit,
  input  logic          ser_vld,
  input  logic          ctl_set,
  input  logic          ctl_clr,
  input  logic          flag_clr,
  input  logic          sector_end,
  output logic [DW-1:0] rd_word,
  output logic          svc_flag,
  output logic          par_err,
  output logic          overrun,
  output logic          rd_active
);
  logic bit_take;
  logic restart;
  logic word_done;

  assign restart  = ctl_set || sector_end;
  assign bit_take = rd_active && ser_vld && !restart;

  rd_deser #(.DW(DW)) u_deser (
    .clk(clk), .por_n(por_n), .en(bit_take), .restart(restart),
    .bit_in(ser_bit), .word_q(rd_word), .word_done(word_done)
  );

  rd_parity u_par (
    .clk(clk), .por_n(por_n), .start(ctl_set), .en(bit_take),
    .bit_in(ser_bit), .word_done(word_done), .par_err(par_err)
  );

  rd_ctrl u_ctrl (
    .clk(clk), .por_n(por_n), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .sector_end(sector_end), .flag_clr(flag_clr), .word_done(word_done),
    .active(rd_active), .svc_flag(svc_flag), .overrun(overrun)
  );

  a_r7_idle_no_word: assert property (@(posedge clk) disable iff (!por_n)
    (!rd_active && !ctl_set) |=> $stable(rd_word));
endmodule

// File: tb/disc_rd_channel_bench.sv
module disc_rd_channel_bench;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  // {data word, parity bit}
  localparam logic [16:0] VEC [NV] = '{
    {16'h0000, 1'b1}, {16'hFFFF, 1'b1}, {16'hA5C3, 1'b0},
    {16'h0001, 1'b0}, {16'h8000, 1'b1}, {16'h1234, 1'b0}
  };

  logic clk = 0, por_n = 0, ser_bit = 0, ser_vld = 0;
  logic ctl_set = 0, ctl_clr = 0, flag_clr = 0, sector_end = 0;
  logic [15:0] rd_word;
  logic svc_flag, par_err, overrun, rd_active;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  disc_rd_channel u_disc_rd_channel (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic send_bit(logic b, logic clr = 0);
    ser_bit = b; ser_vld = 1; flag_clr = clr;
    @(negedge clk);
    ser_vld = 0; flag_clr = 0;
  endtask

  task automatic send_frame(logic [16:0] f, logic clr_last = 0);
    for (int i = 1; i <= 16; i++) send_bit(f[i]);
    send_bit(f[0], clr_last);
  endtask

  function automatic logic bad(logic [16:0] f);
    return ($countones(f) % 2) == 0;
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R10 word", rd_word, 0);
    chk("R10 flags", {svc_flag, par_err, overrun, rd_active}, 0);
    @(negedge clk); por_n = 1; @(negedge clk);

    // R7: idle channel ignores bits
    send_frame({16'hBEEF, 1'b1});
    chk("R7 flag", svc_flag, 0);
    chk("R7 word", rd_word, 0);

    // table walk: R1 R4 R6
    for (int v = 0; v < NV; v++) begin
      pulse(ctl_set);
      send_frame(VEC[v]);
      chk("R1 R6 word", rd_word, VEC[v][16:1]);
      chk("R3 flag", svc_flag, 1);
      chk("R4 parity", par_err, bad(VEC[v]));
      pulse(flag_clr);
      chk("R3 clear", svc_flag, 0);
    end

    // R5: sticky error over a good frame
    pulse(ctl_set);
    send_frame({16'h00F0, 1'b0});
    chk("R5 first", par_err, 1);
    send_frame({16'h0007, 1'b0});
    chk("R5 sticky", par_err, 1);
    chk("R2 new word", rd_word, 16'h0007);
    pulse(ctl_set);
    chk("R5 start clears", par_err, 0);

    // R2: partial frame leaves word held
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    chk("R2 hold", rd_word, 16'h0007);

    // R11: sector_end drops partial, control still set keeps active
    pulse(sector_end);
    chk("R8 stays active", rd_active, 1);
    pulse(flag_clr);
    send_frame({16'h3C01, 1'b0});
    chk("R11 aligned", rd_word, 16'h3C01);
    chk("R11 parity", par_err, 0);

    // R3: clear coinciding with completion keeps flag
    send_frame({16'h0101, 1'b1}, 1'b1);
    chk("R3 set wins", svc_flag, 1);
    chk("R9 no overrun", overrun, 0);

    // R9: second word without clear
    send_frame({16'h0202, 1'b1});
    chk("R9 overrun", overrun, 1);
    chk("R9 replaced", rd_word, 16'h0202);
    pulse(ctl_set);
    chk("R9 cleared", overrun, 0);

    // R8: control cleared, stop at sector end
    pulse(ctl_clr);
    chk("R8 active until sector", rd_active, 1);
    pulse(sector_end);
    chk("R8 idle", rd_active, 0);
    pulse(flag_clr);
    send_frame({16'h5555, 1'b0});
    chk("R7 after stop flag", svc_flag, 0);
    chk("R7 after stop word", rd_word, 16'h0202);

    // R10: power-on clear mid-operation
    pulse(ctl_set);
    por_n = 0; @(negedge clk);
    chk("R10 clear", {rd_word, svc_flag, par_err, overrun, rd_active}, 0);
    por_n = 1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule